// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a bank of receive-side statistics for a few ports. After each received frame, an upstream parser presents a one-cycle summary of it: the port number, the frame length in bytes including CRC, error flags, a drop flag, the class of the destination address, and whether layer-2 parsing applied. The block then updates every counter that the summary selects for that port. Each update finishes in the same clock edge.

Software reads one counter at a time through a small read port. The data appears one cycle after the request. A global read-clear input decides whether a read also zeroes the counter it returned. Each counter saturates at its maximum value and does not wrap. Packet counters are `PKT_W` bits wide and octet counters are `OCT_W` bits wide. The runt and oversize limits come from configuration inputs, which are normally tied to 64 and 1518.

Top module: `rx_port_stats`

## Requirements
- R1: Every frame adds its length to the inbound octet counter (sel 1). A frame with `ev_if_err` low also increments the good-packet counter (sel 0).
- R2: A frame with `ev_if_err` high increments the interface-error counter (sel 2).
- R3: A frame with `ev_drop` high increments the dropped-packet counter (sel 3) and adds its length to the dropped-octet counter (sel 4).
- R4: The destination class is encoded as 0 unicast, 1 multicast, 2 broadcast and 3 unicast. When `ev_l2` is high, class 1 increments the multicast counter (sel 5) and class 2 increments the broadcast counter (sel 6). When `ev_l2` is low, neither counter changes.
- R5: The length histogram has seven bins. Sel 7 counts length 64 and sel 8 counts 65..127. Sel 9 counts 128..255 and sel 10 counts 256..511. Sel 11 counts 512..1023, sel 12 counts 1024..1518, and sel 13 counts 1519 and above. A length below 64 lands in no bin.
- R6: A frame shorter than `cfg_min_len` increments the runt counter (sel 15) when `ev_fcs_err` is low, and the fragment counter (sel 16) when it is high.
- R7: A frame longer than `cfg_max_len` increments the oversize counter (sel 17) when `ev_fcs_err` is low, and the jabber counter (sel 18) when it is high.
- R8: A frame with `ev_fcs_err` or `ev_align_err` high increments the shared FCS/alignment counter (sel 14).
- R9: Every counter is zero after reset. A read request presents the counter's pre-edge value on `rd_data` one cycle later, with `rd_valid` high. A sel of 19 or above returns 0.
- R10: With `rd_clr_en` high, a read zeroes the counter it returned. With `rd_clr_en` low, a read leaves the counter unchanged.
- R11: When a read-clear and an increment hit the same counter in the same cycle, the counter ends at the increment amount: 1 for a packet counter, or the frame length for an octet counter.
- R12: A counter that would exceed its maximum stays at its maximum. The maximum is 2^PKT_W-1 for packet counters and 2^OCT_W-1 for sel 1 and sel 4.
- R13: A frame changes only the counters of the port given by `ev_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_min_len | input | LEN_W | Runt threshold; a length below it is short |
| cfg_max_len | input | LEN_W | Oversize threshold; a length above it is long |
| rd_clr_en | input | 1 | Global read-clear enable |
| ev_valid | input | 1 | Frame summary valid this cycle |
| ev_port | input | PORT_W | Port of the frame |
| ev_len | input | LEN_W | Frame length in bytes including CRC |
| ev_fcs_err | input | 1 | CRC check failed |
| ev_align_err | input | 1 | Alignment error |
| ev_drop | input | 1 | Frame marked for drop |
| ev_if_err | input | 1 | Interface-level receive error |
| ev_dmac_cls | input | 2 | Destination class (0 unicast, 1 multicast, 2 broadcast, 3 unicast) |
| ev_l2 | input | 1 | Layer-2 parsing applied |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_sel | input | 5 | Counter select |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | OCT_W | Read data, zero-extended for packet counters |

## Verification
The bench targets the edges of the histogram bins: 64/65, 127/128 and 1518/1519. An off-by-one compare at any of these edges would move the frame into the neighbouring bin. It also covers the error splits: a runt or oversize frame with and without a CRC error, and a design that crossed those flags would put each frame in the wrong one of the pair. Two cases check that frames are left out when they should be. A broadcast frame without layer-2 parsing must not reach either address-class counter. A frame with an interface error must not reach the good-packet count.

The same-cycle collision of a read-clear with an increment is driven directly. A design that lets the clear win would lose that event, and one that lets the increment win would leave a stale count. The bench also pushes one port past saturation on both a narrow packet counter and an octet counter, where a wrapping adder would read back a small value. Events sent to one port are read back from the others, so an update that leaks across ports shows up.

// File: rtl/rx_port_stats.sv
module rx_port_stats #(
  parameter int NUM_PORTS = 4,
  parameter int LEN_W     = 14,
  parameter int PKT_W     = 32,
  parameter int OCT_W     = 48,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_min_len,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              rd_clr_en,
  input  logic              ev_valid,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_fcs_err,
  input  logic              ev_align_err,
  input  logic              ev_drop,
  input  logic              ev_if_err,
  input  logic [1:0]        ev_dmac_cls,
  input  logic              ev_l2,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [4:0]        rd_sel,
  output logic              rd_valid,
  output logic [OCT_W-1:0]  rd_data
);

  localparam int NUM_CNT = 19;
  localparam int TOTAL   = NUM_PORTS * NUM_CNT;
  localparam int IDX_W   = $clog2(TOTAL + 1) + 1;
  localparam logic [OCT_W:0] ONE = 1;

  logic [NUM_CNT-1:0] hit;
  logic [OCT_W-1:0]   cnt_flat [TOTAL];
  logic               short_f, long_f;

  assign short_f = ev_len < cfg_min_len;
  assign long_f  = ev_len > cfg_max_len;

  always_comb begin
    hit     = '0;
    hit[0]  = !ev_if_err;
    hit[1]  = 1'b1;
    hit[2]  = ev_if_err;
    hit[3]  = ev_drop;
    hit[4]  = ev_drop;
    hit[5]  = ev_l2 && (ev_dmac_cls == 2'd1);
    hit[6]  = ev_l2 && (ev_dmac_cls == 2'd2);
    hit[7]  = ev_len == LEN_W'(64);
    hit[8]  = (ev_len >= LEN_W'(65))   && (ev_len <= LEN_W'(127));
    hit[9]  = (ev_len >= LEN_W'(128))  && (ev_len <= LEN_W'(255));
    hit[10] = (ev_len >= LEN_W'(256))  && (ev_len <= LEN_W'(511));
    hit[11] = (ev_len >= LEN_W'(512))  && (ev_len <= LEN_W'(1023));
    hit[12] = (ev_len >= LEN_W'(1024)) && (ev_len <= LEN_W'(1518));
    hit[13] = ev_len >= LEN_W'(1519);
    hit[14] = ev_fcs_err || ev_align_err;
    hit[15] = short_f && !ev_fcs_err;
    hit[16] = short_f && ev_fcs_err;
    hit[17] = long_f && !ev_fcs_err;
    hit[18] = long_f && ev_fcs_err;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      localparam bit IS_OCT = (k == 1) || (k == 4);
      localparam logic [OCT_W:0] LIM = IS_OCT ? (ONE << OCT_W) - ONE : (ONE << PKT_W) - ONE;

      logic             inc, clr;
      logic [OCT_W:0]   amt, base, sum;
      logic [OCT_W-1:0] q;

      assign inc  = ev_valid && (ev_port == PORT_W'(p)) && hit[k];
      assign clr  = rd_en && rd_clr_en && (rd_port == PORT_W'(p)) && (rd_sel == 5'(k));
      assign amt  = !inc ? '0 : (IS_OCT ? (OCT_W+1)'(ev_len) : ONE);
      assign base = clr ? '0 : {1'b0, q};
      assign sum  = base + amt;

      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (sum > LIM) ? LIM[OCT_W-1:0] : sum[OCT_W-1:0];
      end

      assign cnt_flat[p*NUM_CNT + k] = q;

      AST_NO_WRAP:   assert property (@(posedge clk) disable iff (!rst_n) !clr |=> q >= $past(q)); // R12
      AST_CLR_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) clr && !inc |=> q == '0); // R10
      if (!IS_OCT) begin : g_pk
        AST_CLR_KEEP_INC: assert property (@(posedge clk) disable iff (!rst_n) clr && inc |=> q == OCT_W'(1)); // R11
      end
    end
  end

  logic [IDX_W-1:0] rd_idx;
  logic             rd_ok;
  assign rd_idx = IDX_W'(rd_port) * IDX_W'(NUM_CNT) + IDX_W'(rd_sel);
  assign rd_ok  = (rd_sel < 5'(NUM_CNT)) && (int'(rd_port) < NUM_PORTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_ok ? cnt_flat[rd_idx] : '0;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R9
  AST_RD_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R9
  AST_ONE_BIN:    assert property (@(posedge clk) disable iff (!rst_n) ev_valid |-> $onehot0(hit[13:7])); // R5
  AST_MC_BC_EXCL: assert property (@(posedge clk) disable iff (!rst_n) ev_valid |-> $onehot0(hit[6:5])); // R4
  AST_LEN_SPLIT:  assert property (@(posedge clk) disable iff (!rst_n)
                    ev_valid && (cfg_min_len <= cfg_max_len) |-> $onehot0(hit[18:15])); // R6

endmodule

// File: tb/rx_port_stats_tb.sv
`timescale 1ns/1ps
module rx_port_stats_tb;
  localparam int NP = 4, LW = 14, PW = 8, OW = 16;

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] cfg_min_len = 64, cfg_max_len = 1518;
  logic rd_clr_en = 0, ev_valid = 0, ev_fcs_err = 0, ev_align_err = 0, ev_drop = 0, ev_if_err = 0, ev_l2 = 0;
  logic [1:0] ev_port = 0, rd_port = 0, ev_dmac_cls = 0;
  logic [LW-1:0] ev_len = 0;
  logic rd_en = 0;
  logic [4:0] rd_sel = 0;
  logic rd_valid;
  logic [OW-1:0] rd_data;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  rx_port_stats #(.NUM_PORTS(NP), .LEN_W(LW), .PKT_W(PW), .OCT_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
    .rd_clr_en(rd_clr_en), .ev_valid(ev_valid), .ev_port(ev_port), .ev_len(ev_len),
    .ev_fcs_err(ev_fcs_err), .ev_align_err(ev_align_err), .ev_drop(ev_drop),
    .ev_if_err(ev_if_err), .ev_dmac_cls(ev_dmac_cls), .ev_l2(ev_l2),
    .rd_en(rd_en), .rd_port(rd_port), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data));

  typedef struct packed {
    logic [13:0] len; logic fcs; logic aln; logic drp; logic ife;
    logic [1:0] cls; logic l2; logic [18:0] m;
  } vec_t;

  localparam logic [18:0] GD = 19'(1) << 0,  OC = 19'(1) << 1,  IE = 19'(1) << 2,
                          DP = 19'(1) << 3,  DO = 19'(1) << 4,  MC = 19'(1) << 5,
                          BC = 19'(1) << 6,  B64 = 19'(1) << 7, B65 = 19'(1) << 8,
                          B128 = 19'(1) << 9, B256 = 19'(1) << 10, B512 = 19'(1) << 11,
                          B1K = 19'(1) << 12, B15 = 19'(1) << 13, FA = 19'(1) << 14,
                          RU = 19'(1) << 15, FR = 19'(1) << 16, OV = 19'(1) << 17,
                          JB = 19'(1) << 18, GO = GD | OC;

  localparam vec_t VT [14] = '{
    '{14'd64,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, GO | B64},
    '{14'd100,  1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, GO | MC | B65},
    '{14'd200,  1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, GO | BC | B128},
    '{14'd300,  1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, GO | B256},
    '{14'd600,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, GO | B512 | FA},
    '{14'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, GO | B1K | FA},
    '{14'd1519, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, GO | B15 | OV},
    '{14'd2000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, GO | B15 | JB | FA},
    '{14'd40,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, GO | RU},
    '{14'd40,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, GO | FR | FA},
    '{14'd127,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, GO | DP | DO | B65},
    '{14'd128,  1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, OC | IE | B128},
    '{14'd1024, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, GO | B1K},
    '{14'd65,   1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, GO | B65}
  };

  function automatic string req_of(int s);
    case (s)
      0, 1: return "R1";
      2: return "R2";
      3, 4: return "R3";
      5, 6: return "R4";
      14: return "R8";
      15, 16: return "R6";
      17, 18: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [OW-1:0] got, logic [OW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic send(logic [1:0] p, logic [LW-1:0] len, logic fcs, logic aln,
                      logic drp, logic ife, logic [1:0] cls, logic l2);
    @(negedge clk);
    ev_valid = 1; ev_port = p; ev_len = len; ev_fcs_err = fcs; ev_align_err = aln;
    ev_drop = drp; ev_if_err = ife; ev_dmac_cls = cls; ev_l2 = l2;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic rd(logic [1:0] p, logic [4:0] s, logic clr, output logic [OW-1:0] d);
    @(negedge clk);
    rd_en = 1; rd_port = p; rd_sel = s; rd_clr_en = clr;
    @(negedge clk);
    d = rd_data;
    if (rd_valid !== 1'b1) begin total++; bad++; $display("FAIL R9 actual=rd_valid %b expected=1", rd_valid); end
    rd_en = 0; rd_clr_en = 0;
  endtask

  task automatic wipe(logic [1:0] p);
    logic [OW-1:0] d;
    for (int s = 0; s < 19; s++) rd(p, 5'(s), 1'b1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 actual=hung expected=finished (watchdog)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [OW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9: reset state and out-of-range select
    rd(0, 0, 0, d);  chk("R9", d, 0);
    rd(0, 1, 0, d);  chk("R9", d, 0);
    rd(3, 18, 0, d); chk("R9", d, 0);

    // Table walk: one frame on port 1, then read-clear all counters
    for (int i = 0; i < 14; i++) begin
      send(1, VT[i].len, VT[i].fcs, VT[i].aln, VT[i].drp, VT[i].ife, VT[i].cls, VT[i].l2);
      for (int s = 0; s < 19; s++) begin
        logic [OW-1:0] e;
        e = VT[i].m[s] ? ((s == 1 || s == 4) ? OW'(VT[i].len) : OW'(1)) : '0;
        rd(1, 5'(s), 1'b1, d);
        chk(req_of(s), d, e);
      end
    end

    // R10: plain reads keep the value, clear reads zero it
    send(1, 70, 0, 0, 0, 0, 0, 0);
    rd(1, 0, 0, d); chk("R10", d, 1);
    rd(1, 0, 0, d); chk("R10", d, 1);
    rd(1, 0, 1, d); chk("R10", d, 1);
    rd(1, 0, 0, d); chk("R10", d, 0);
    rd(1, 25, 0, d); chk("R9", d, 0);
    wipe(1);

    // R13: ports are independent
    send(2, 64, 0, 0, 0, 0, 0, 0);
    rd(1, 0, 0, d); chk("R13", d, 0);
    rd(3, 7, 0, d); chk("R13", d, 0);
    rd(2, 0, 1, d); chk("R13", d, 1);
    rd(2, 1, 1, d); chk("R13", d, 64);
    rd(2, 7, 1, d); chk("R13", d, 1);

    // R11: clear and increment in the same cycle
    send(1, 300, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    ev_valid = 1; ev_port = 1; ev_len = 200; ev_fcs_err = 0; ev_align_err = 0;
    ev_drop = 0; ev_if_err = 0; ev_dmac_cls = 0; ev_l2 = 0;
    rd_en = 1; rd_port = 1; rd_sel = 0; rd_clr_en = 1;
    @(negedge clk);
    chk("R11", rd_data, 1);
    ev_valid = 0; rd_en = 0; rd_clr_en = 0;
    rd(1, 0, 1, d); chk("R11", d, 1);
    rd(1, 1, 0, d); chk("R11", d, 500);
    @(negedge clk);
    ev_valid = 1; ev_port = 1; ev_len = 90;
    rd_en = 1; rd_port = 1; rd_sel = 1; rd_clr_en = 1;
    @(negedge clk);
    chk("R11", rd_data, 500);
    ev_valid = 0; rd_en = 0; rd_clr_en = 0;
    rd(1, 1, 1, d); chk("R11", d, 90);
    wipe(1);

    // R6 / R7: programmable limits
    cfg_min_len = 100;
    send(1, 80, 0, 0, 0, 0, 0, 0);
    rd(1, 15, 1, d); chk("R6", d, 1);
    rd(1, 8, 1, d);  chk("R5", d, 1);
    cfg_min_len = 64; cfg_max_len = 1000;
    send(1, 1200, 1, 0, 0, 0, 0, 0);
    rd(1, 18, 1, d); chk("R7", d, 1);
    rd(1, 17, 1, d); chk("R7", d, 0);
    rd(1, 12, 1, d); chk("R5", d, 1);
    cfg_max_len = 1518;
    wipe(1);

    // R12: saturation on packet and octet counters
    for (int n = 0; n < 260; n++) send(3, 1500, 0, 0, 0, 0, 0, 0);
    rd(3, 0, 0, d);  chk("R12", d, 255);
    rd(3, 12, 0, d); chk("R12", d, 255);
    rd(3, 1, 1, d);  chk("R12", d, 16'hFFFF);
    rd(3, 1, 0, d);  chk("R12", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule